// File: doc/BRIEF.md
# Memory-Mapped Cache Array Access Port

This block holds the tag and data storage of a four-way set-associative cache and lets software reach both through ordinary memory-mapped loads and stores. A single 32-bit request port carries the address, the write flag and the write word. The top byte of the address steers each access either to the status side (tag, valid bit, dirty bit) or to the longword side (four 32-bit words per 16-byte line). The set, the way and the word within the line are taken from fixed address fields.

Besides plain reads and writes, the status side has an associative write. It compares a supplied tag against every way of one set and rewrites only the valid and dirty bits of the way that matches. The tag is never changed by this write. If the matching line was dirty, the block emits a one-cycle write-back request carrying that line's tag, set and way. It then holds the request port busy until the request is acknowledged. Refill, normal lookups and the bus transfer of a write-back are handled elsewhere.

Top module: `cache_array_port`

## Requirements
- R1: Address byte 31:24 equal to 0xF0 selects the status side and 0xF1 selects the longword side. For any other value a write changes nothing and a read returns 0.
- R2: On the longword side, bits 11:4 select the set, bits 13:12 the way (00 to 11 for ways 0 to 3) and bits 3:2 the word (00 to 11 for words 0 to 3). A write stores req_wdata there. A read returns that word on rsp_rdata with rsp_valid high in the cycle after acceptance.
- R3: Longword-side writes leave every tag, valid bit and dirty bit unchanged.
- R4: A status-side write with address bit 3 at 0 stores tag = wdata[31:10], dirty = wdata[1] and valid = wdata[0] into the way chosen by bits 13:12 of the set in bits 11:4. A status-side read returns the tag in bits 31:10, dirty in bit 1 and valid in bit 0, with bits 9:2 at 0.
- R5: When valid is written as 0, the stored dirty bit becomes 0 whatever wdata[1] holds.
- R6: A status-side write with address bit 3 at 1 is associative. A way matches when it is valid and its tag equals wdata[31:10]. If a way matches, only that way takes the new dirty and valid bits, and every tag stays as it was.
- R7: An associative write with no matching way changes nothing and raises no write-back.
- R8: If the matching way was dirty before an associative write, wb_req is high for exactly one cycle, in the cycle after acceptance. In that cycle wb_tag, wb_index and wb_way give the line's tag, set and way.
- R9: req_ready is low from the cycle wb_req rises until the clock edge at which wb_ack is sampled high. It is high again in the next cycle.
- R10: An access with address bits 1:0 not equal to 00 is ignored: a write changes nothing and a read returns 0.
- R11: After reset req_ready is 1, rsp_valid and wb_req are 0, and every line reads back as invalid and clean with a zero tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Mapped address |
| req_wdata | input | 32 | Write word |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Read result present |
| rsp_rdata | output | 32 | Read result |
| wb_req | output | 1 | Write-back request pulse |
| wb_tag | output | 22 | Tag of line to write back |
| wb_index | output | 8 | Set of line to write back |
| wb_way | output | 2 | Way of line to write back |
| wb_ack | input | 1 | Write-back acknowledge |

## Verification
Read results and write-back pulses both appear one cycle after the clock edge that accepts the request. Stored state changes at that same edge, so a read issued next sees the new contents. The driver queues the expected read word, or the expected write-back triple, before it presents a request. A monitor compares each result at the falling edge that follows the accepting edge. That falling edge is also where the driver checks req_ready low after a dirty hit. The acknowledge is driven three falling edges after the pulse, and a request is only issued once ready has returned.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_TAG  = 2'd1,
      RGN_DATA = 2'd2
   } region_e;
endpackage

// File: rtl/cap_decode.sv
module cap_decode
   import cap_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          IDX_W    = 8,
   parameter int          WAY_W    = 2,
   parameter int          WORD_W   = 2,
   parameter logic [7:0]  TAG_SEL  = 8'hF0,
   parameter logic [7:0]  DATA_SEL = 8'hF1
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [IDX_W-1:0]  idx,
   output logic [WAY_W-1:0]  way,
   output logic [WORD_W-1:0] word,
   output logic              assoc,
   output logic              aligned
);
   localparam int IDX_LO = 2 + WORD_W;
   localparam int WAY_LO = IDX_LO + IDX_W;

   if (WAY_LO + WAY_W > ADDR_W - 8) begin : g_bad_fields
      $error("cap_decode: address fields overlap the region byte");
   end

   always_comb begin
      unique case (addr[ADDR_W-1 -: 8])
         TAG_SEL:  region = RGN_TAG;
         DATA_SEL: region = RGN_DATA;
         default:  region = RGN_NONE;
      endcase
   end

   assign idx     = addr[IDX_LO +: IDX_W];
   assign way     = addr[WAY_LO +: WAY_W];
   assign word    = addr[2 +: WORD_W];
   assign assoc   = addr[IDX_LO-1];
   assign aligned = (addr[1:0] == 2'b00);
endmodule

// File: rtl/cap_tag_store.sv
module cap_tag_store #(
   parameter int SETS  = 256,
   parameter int WAYS  = 4,
   parameter int TAG_W = 22,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             assoc_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [WAY_W-1:0] way,
   input  logic [TAG_W-1:0] wtag,
   input  logic             wdirty,
   input  logic             wvalid,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_dirty,
   output logic             rd_valid,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way,
   output logic             hit_dirty,
   output logic [TAG_W-1:0] hit_tag
);
   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic             dirty_q [SETS][WAYS];
   logic             valid_q [SETS][WAYS];
   logic [WAYS-1:0]  match;

   // One comparator per way
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = valid_q[idx][w] && (tag_q[idx][w] == wtag);
   end

   // Lowest matching way wins
   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (match[w]) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end

   assign hit_dirty = dirty_q[idx][hit_way];
   assign hit_tag   = tag_q[idx][hit_way];
   assign rd_tag    = tag_q[idx][way];
   assign rd_dirty  = dirty_q[idx][way];
   assign rd_valid  = valid_q[idx][way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w]   <= '0;
               dirty_q[s][w] <= 1'b0;
               valid_q[s][w] <= 1'b0;
            end
         end
      end else if (wr_en) begin
         tag_q[idx][way]   <= wtag;
         valid_q[idx][way] <= wvalid;
         dirty_q[idx][way] <= wdirty & wvalid;
      end else if (assoc_en && hit) begin
         valid_q[idx][hit_way] <= wvalid;
         dirty_q[idx][hit_way] <= wdirty & wvalid;
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_chk
      // R5: a write never leaves an invalid line marked dirty
      a_r5_no_dirty_invalid: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en || assoc_en) |=> !(dirty_q[$past(idx)][w] && !valid_q[$past(idx)][w]));
      // R6: associative writes keep every tag of the set
      a_r6_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (assoc_en && !wr_en) |=> (tag_q[$past(idx)][w] == $past(tag_q[idx][w])));
   end
endmodule

// File: rtl/cap_data_store.sv
module cap_data_store #(
   parameter int SETS   = 256,
   parameter int WAYS   = 4,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS),
   localparam int WORD_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WAY_W-1:0]  way,
   input  logic [WORD_W-1:0] word,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = SETS * WORDS;

   logic [DATA_W-1:0] way_rd [WAYS];
   logic [IDX_W+WORD_W-1:0] loc;

   assign loc = {idx, word};

   // One bank per way
   for (genvar w = 0; w < WAYS; w++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (way == WAY_W'(w))) mem[loc] <= wdata;
      end
      assign way_rd[w] = mem[loc];
   end

   assign rdata = way_rd[way];
endmodule

// File: rtl/cache_array_port.sv
module cache_array_port
   import cap_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          WAYS     = 4,
   parameter int          SETS     = 256,
   parameter int          WORDS    = 4,
   parameter int          TAG_LSB  = 10,
   parameter logic [7:0]  TAG_SEL  = 8'hF0,
   parameter logic [7:0]  DATA_SEL = 8'hF1,
   localparam int TAG_W  = ADDR_W - TAG_LSB,
   localparam int IDX_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_rdata,
   output logic              wb_req,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [IDX_W-1:0]  wb_index,
   output logic [WAY_W-1:0]  wb_way,
   input  logic              wb_ack
);
   localparam int WORD_W = $clog2(WORDS);
   localparam int PAD_W  = TAG_LSB - 2;

   if ((1 << WAY_W) != WAYS || (1 << IDX_W) != SETS || (1 << WORD_W) != WORDS)
   begin : g_bad_pow2
      $error("cache_array_port: ways, sets and words must be powers of two");
   end
   if (TAG_LSB < 3 || WORD_W < 1) begin : g_bad_tag
      $error("cache_array_port: tag field must leave room for status bits");
   end

   region_e           rgn;
   logic [IDX_W-1:0]  idx;
   logic [WAY_W-1:0]  way;
   logic [WORD_W-1:0] word;
   logic              assoc, aligned;
   logic              accept, do_data_wr, do_tag_wr, do_assoc;
   logic [TAG_W-1:0]  rd_tag, hit_tag;
   logic              rd_dirty, rd_valid, hit, hit_dirty;
   logic [WAY_W-1:0]  hit_way;
   logic [ADDR_W-1:0] data_rd, rd_next;
   logic              wb_pend;

   cap_decode #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAY_W(WAY_W), .WORD_W(WORD_W),
      .TAG_SEL(TAG_SEL), .DATA_SEL(DATA_SEL)
   ) u_dec (
      .addr(req_addr), .region(rgn), .idx(idx), .way(way), .word(word),
      .assoc(assoc), .aligned(aligned)
   );

   assign req_ready  = !wb_pend;
   assign accept     = req_valid && req_ready;
   assign do_data_wr = accept && req_write && aligned && (rgn == RGN_DATA);
   assign do_tag_wr  = accept && req_write && aligned && (rgn == RGN_TAG) && !assoc;
   assign do_assoc   = accept && req_write && aligned && (rgn == RGN_TAG) && assoc;

   cap_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .wr_en(do_tag_wr), .assoc_en(do_assoc),
      .idx(idx), .way(way), .wtag(req_wdata[ADDR_W-1:TAG_LSB]),
      .wdirty(req_wdata[1]), .wvalid(req_wdata[0]),
      .rd_tag(rd_tag), .rd_dirty(rd_dirty), .rd_valid(rd_valid),
      .hit(hit), .hit_way(hit_way), .hit_dirty(hit_dirty), .hit_tag(hit_tag)
   );

   cap_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(ADDR_W)) u_data (
      .clk(clk), .we(do_data_wr), .idx(idx), .way(way), .word(word),
      .wdata(req_wdata), .rdata(data_rd)
   );

   always_comb begin
      rd_next = '0;
      if (aligned) begin
         if (rgn == RGN_DATA)     rd_next = data_rd;
         else if (rgn == RGN_TAG) rd_next = {rd_tag, {PAD_W{1'b0}}, rd_dirty, rd_valid};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= accept && !req_write;
         if (accept && !req_write) rsp_rdata <= rd_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_req   <= 1'b0;
         wb_pend  <= 1'b0;
         wb_tag   <= '0;
         wb_index <= '0;
         wb_way   <= '0;
      end else begin
         wb_req <= 1'b0;
         if (do_assoc && hit && hit_dirty) begin
            wb_req   <= 1'b1;
            wb_pend  <= 1'b1;
            wb_tag   <= hit_tag;
            wb_index <= idx;
            wb_way   <= hit_way;
         end else if (wb_pend && wb_ack) begin
            wb_pend <= 1'b0;
         end
      end
   end

   // R9: port is busy while a write-back is outstanding
   a_r9_busy_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> !req_ready);
   // R9: ready comes back once the acknowledge is taken
   a_r9_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_pend && wb_ack) |=> req_ready);
   // R8: write-back request lasts a single cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |=> !wb_req);
   // R2: a response only follows an accepted read
   a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready && !req_write));
endmodule

// File: tb/cache_array_port_tb.sv
module cache_array_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_ready, rsp_valid, wb_req;
   logic [31:0] rsp_rdata;
   logic [21:0] wb_tag;
   logic [7:0]  wb_index;
   logic [1:0]  wb_way;
   logic        wb_ack = 1'b0;

   int checks = 0, errors = 0;
   logic [31:0] exp_q[$];
   string       exp_r[$];
   logic [31:0] wb_q[$];
   string       wb_r[$];
   int          ack_delay = 0;

   always #4 clk = ~clk;

   cache_array_port u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wb_req(wb_req),
      .wb_tag(wb_tag), .wb_index(wb_index), .wb_way(wb_way), .wb_ack(wb_ack)
   );

   task automatic check(input bit ok, input string r, input logic [31:0] act, exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   function automatic logic [31:0] adr(input logic [7:0] top, input int set,
                                       input int way, input int wd, input int low);
      return {top, 10'b0, way[1:0], set[7:0], wd[1:0], low[1:0]};
   endfunction

   function automatic logic [31:0] st(input logic [21:0] tag, input bit u, input bit v);
      return {tag, 8'b0, u, v};
   endfunction

   task automatic send(input logic wr, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, input logic [31:0] e, input string r);
      exp_q.push_back(e);
      exp_r.push_back(r);
      send(1'b0, a, '0);
   endtask

   // Monitor: read responses, write-back pulses and the acknowledge
   always @(negedge clk) begin
      if (rsp_valid) begin
         if (exp_q.size() == 0) check(1'b0, "R2 unexpected response", rsp_rdata, '0);
         else begin
            logic [31:0] e;
            string r;
            e = exp_q.pop_front();
            r = exp_r.pop_front();
            check(rsp_rdata === e, r, rsp_rdata, e);
         end
      end
      wb_ack = 1'b0;
      if (ack_delay > 0) begin
         ack_delay--;
         if (ack_delay == 0) wb_ack = 1'b1;
      end
      if (wb_req) begin
         ack_delay = 3;
         if (wb_q.size() == 0)
            check(1'b0, "R7 unexpected write-back", {wb_tag, wb_index, wb_way}, '0);
         else begin
            logic [31:0] e;
            string r;
            e = wb_q.pop_front();
            r = wb_r.pop_front();
            check({wb_tag, wb_index, wb_way} === e, r, {wb_tag, wb_index, wb_way}, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(req_ready === 1'b1, "R11 ready", {31'b0, req_ready}, 1);
      check(rsp_valid === 1'b0, "R11 rsp_valid", {31'b0, rsp_valid}, 0);
      check(wb_req === 1'b0, "R11 wb_req", {31'b0, wb_req}, 0);
      rd(adr(8'hF0, 5, 2, 0, 0), 32'h0, "R11 line reset invalid");

      // R2 longword writes and reads
      send(1'b1, adr(8'hF1, 8'h12, 1, 2, 0), 32'hA5A5_0001);
      send(1'b1, adr(8'hF1, 8'h12, 1, 3, 0), 32'h5A5A_0002);
      send(1'b1, adr(8'hF1, 8'h12, 2, 2, 0), 32'h1234_5678);
      send(1'b1, adr(8'hF1, 8'hFF, 3, 0, 0), 32'hDEAD_BEEF);
      rd(adr(8'hF1, 8'h12, 1, 2, 0), 32'hA5A5_0001, "R2 set12 way1 word2");
      rd(adr(8'hF1, 8'h12, 1, 3, 0), 32'h5A5A_0002, "R2 set12 way1 word3");
      rd(adr(8'hF1, 8'h12, 2, 2, 0), 32'h1234_5678, "R2 set12 way2 word2");
      rd(adr(8'hF1, 8'hFF, 3, 0, 0), 32'hDEAD_BEEF, "R2 last set way3");
      // R3 status untouched by longword writes
      rd(adr(8'hF0, 8'h12, 1, 0, 0), 32'h0, "R3 status after data write");

      // R4 / R5 direct status writes
      send(1'b1, adr(8'hF0, 8'h30, 0, 0, 0), st(22'h1ABCD, 1, 1));
      send(1'b1, adr(8'hF0, 8'h30, 3, 0, 0), st(22'h00777, 0, 1));
      send(1'b1, adr(8'hF0, 8'h30, 1, 0, 0), st(22'h2FFFF, 1, 0) | 32'h3FC);
      rd(adr(8'hF0, 8'h30, 0, 0, 0), st(22'h1ABCD, 1, 1), "R4 way0 readback");
      rd(adr(8'hF0, 8'h30, 3, 0, 0), st(22'h00777, 0, 1), "R4 way3 readback");
      rd(adr(8'hF0, 8'h30, 1, 0, 0), st(22'h2FFFF, 0, 0), "R5 invalid clears dirty");

      // R1 other regions ignored
      send(1'b1, adr(8'h55, 8'h12, 1, 2, 0), 32'hFFFF_FFFF);
      rd(adr(8'hF1, 8'h12, 1, 2, 0), 32'hA5A5_0001, "R1 foreign write ignored");
      rd(adr(8'h55, 8'h12, 1, 2, 0), 32'h0, "R1 foreign read zero");

      // R10 misaligned ignored
      send(1'b1, adr(8'hF1, 8'h12, 1, 2, 1), 32'h0BAD_0BAD);
      rd(adr(8'hF1, 8'h12, 1, 2, 0), 32'hA5A5_0001, "R10 misaligned write ignored");
      rd(adr(8'hF1, 8'h12, 1, 2, 2), 32'h0, "R10 misaligned read zero");

      // R7 associative miss (tag absent, and tag only in invalid way)
      send(1'b1, adr(8'hF0, 8'h30, 0, 2, 0), st(22'h3_0009, 0, 0));
      send(1'b1, adr(8'hF0, 8'h30, 0, 2, 0), st(22'h2FFFF, 1, 1));
      rd(adr(8'hF0, 8'h30, 0, 0, 0), st(22'h1ABCD, 1, 1), "R7 miss way0 kept");
      rd(adr(8'hF0, 8'h30, 1, 0, 0), st(22'h2FFFF, 0, 0), "R7 invalid way not hit");

      // R6 clean hit in way 3: only way 3 status changes, no write-back
      send(1'b1, adr(8'hF0, 8'h30, 0, 2, 0), st(22'h00777, 1, 1));
      rd(adr(8'hF0, 8'h30, 3, 0, 0), st(22'h00777, 1, 1), "R6 hit way3 updated");
      rd(adr(8'hF0, 8'h30, 0, 0, 0), st(22'h1ABCD, 1, 1), "R6 other way kept");

      // R8 / R9 dirty hit in way 0 with invalidate
      wb_q.push_back({22'h1ABCD, 8'h30, 2'd0});
      wb_r.push_back("R8 write-back fields");
      send(1'b1, adr(8'hF0, 8'h30, 2, 2, 0), st(22'h1ABCD, 1, 0));
      check(req_ready === 1'b0, "R9 busy after dirty hit", {31'b0, req_ready}, 0);
      @(negedge clk);
      check(req_ready === 1'b0, "R9 still busy before ack", {31'b0, req_ready}, 0);
      while (!req_ready) @(negedge clk);
      check(wb_q.size() == 0, "R8 write-back seen", wb_q.size(), 0);
      rd(adr(8'hF0, 8'h30, 0, 0, 0), st(22'h1ABCD, 0, 0), "R6 tag kept, invalidated");
      rd(adr(8'hF1, 8'h12, 2, 2, 0), 32'h1234_5678, "R2 data survives status ops");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule